// File: doc/BRIEF.md
# PCI Legacy Interrupt Router

This block merges the four level-sensitive legacy interrupt pins (INTA through INTD) of several PCI devices onto four shared host interrupt lines. Each device reports its pins together with its slot number. The output index for a pin is found by rotating the pin number by the slot plus a fixed offset, and the offset depends on a board-variant strap. Each host line is the OR of every pin currently routed to it.

Older system software expects a routing with no rotation. The block tells the two kinds of software apart by snooping configuration-space writes to the Interrupt Line register (offset 0x3C). The first such write that could tell the two routings apart fixes the routing mode. Writing the value 27 selects identity routing, and any other value keeps rotated routing. After that first decision the mode holds until reset. On the alternate board variant detection is off, and rotation always applies.

Top module: `pci_intx_router`

## Requirements
- R1: After reset `route_mode` reads 0 (assume-ok) and routing is rotated. The mode encoding is 0 = assume-ok, 1 = identity (legacy), 2 = forced rotation.
- R2: The mode leaves assume-ok only on a write strobe whose offset bits [7:0] equal 0x3C, and only while `alt_board` is 0. Writes at other offsets, or any write while `alt_board` is 1, leave the mode unchanged.
- R3: The slot of a snooped write is offset bits [15:11]. A write whose slot modulo 4 equals 2 leaves the mode unchanged.
- R4: In a qualifying write, if `cfg_wdata[7:0]` equals 27 the mode becomes 1, and any other byte value makes it 2. `cfg_wdata[31:8]` is not compared. The new mode is visible on the cycle after the write strobe.
- R5: Once the mode is 1 or 2 it never changes until reset, whatever writes follow.
- R6: In mode 1 on the original board (`alt_board` = 0), pin n (INTA = 0 … INTD = 3) of any device drives `host_irq[n]`, whatever the slot.
- R7: On the original board in modes 0 and 2, pin p of a device in slot s drives `host_irq[(s + p + 2) mod 4]`.
- R8: With `alt_board` = 1, pin p of slot s drives `host_irq[(s + p + 3) mod 4]`.
- R9: Each `host_irq` bit is the OR of all device pins routed to it. It follows pin levels with no clock delay, and it is 0 when no pin is high.
- R10: Offset bits [23:16] have no effect on the snoop decision.
- R11: `cfg_size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A write with size 3 is ignored by the snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_board | input | 1 | Board-variant strap: 1 selects the +3 rotation and turns detection off |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 24 | Configuration window offset of the write |
| cfg_wdata | input | 32 | Write data, with the byte at the offset in bits [7:0] |
| cfg_size | input | 2 | Access size code |
| dev_intx | input | NUM_DEV*4 | Pin levels, device d pin p at bit d*4+p |
| dev_slot | input | NUM_DEV*5 | Slot number of device d at bits d*5 +: 5 |
| host_irq | output | 4 | Shared level-sensitive host interrupt lines |
| route_mode | output | 2 | Current routing mode |

## Verification
The bench builds the router with NUM_DEV = 2. This is small enough to visit every slot and pin of one device in each of the three routing behaviours (rotated +2, identity, rotated +3), and to walk all 256 level combinations of both devices' eight pins for the OR merge. Snoop decisions are driven one cycle at a time. These cover the rejected cases (wrong offset, slot 2 modulo 4, reserved size, alternate strap) and both ways out of assume-ok, with later writes used to show the mode does not move again.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;

  typedef enum logic [1:0] {
    MODE_ASSUME = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_FORCED = 2'd2
  } route_mode_e;

  localparam int unsigned PINS_PER_DEV = 4;
  localparam int unsigned SLOT_W       = 5;
  localparam logic [7:0]  LINE_REG_OFF = 8'h3C;
  localparam logic [7:0]  LEGACY_LINE  = 8'd27;
  localparam logic [1:0]  SIZE_RSVD    = 2'd3;

  // Slot field of a configuration offset: device number bits of devfn.
  function automatic logic [SLOT_W-1:0] offset_slot(input logic [23:0] off);
    return off[15:11];
  endfunction

  // Host line for one pin; identity only applies on the original board.
  function automatic logic [1:0] route_index(input logic [SLOT_W-1:0] slot,
                                             input logic [1:0] pin,
                                             input logic identity,
                                             input logic alt);
    logic [6:0] sum;
    sum = 7'(slot) + 7'(pin) + (alt ? 7'd3 : 7'd2);
    if (identity && !alt) return pin;
    return sum[1:0];
  endfunction

endpackage

// File: rtl/irq_cfg_snoop.sv
module irq_cfg_snoop
  import pci_irq_pkg::*;
(
  input  logic        detect_en,
  input  logic        wr_en,
  input  logic [23:0] addr,
  input  logic [31:0] wdata,
  input  logic [1:0]  size,
  output logic        hit,
  output logic        hit_legacy
);
  logic [SLOT_W-1:0] slot;
  logic              line_reg;
  logic              slot_differs;
  logic              size_ok;
  logic              unused_bits;

  assign slot         = offset_slot(addr);
  assign line_reg     = (addr[7:0] == LINE_REG_OFF);
  assign slot_differs = (slot[1:0] != 2'd2);
  assign size_ok      = (size != SIZE_RSVD);
  assign hit          = detect_en && wr_en && size_ok && line_reg && slot_differs;
  assign hit_legacy   = (wdata[7:0] == LEGACY_LINE);
  assign unused_bits  = ^{addr[23:16], addr[10:8], wdata[31:8]};

endmodule

// File: rtl/irq_mode_tracker.sv
module irq_mode_tracker
  import pci_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alt_board,
  input  logic        hit,
  input  logic        hit_legacy,
  output route_mode_e mode_q
);
  route_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_q == MODE_ASSUME && hit)
      mode_d = hit_legacy ? MODE_LEGACY : MODE_FORCED;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_ASSUME;
    else        mode_q <= mode_d;
  end

  assert_reset_mode_R1: assert property (@(posedge clk)
    !rst_n |=> mode_q == MODE_ASSUME);

  assert_sticky_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_ASSUME) |=> $stable(mode_q));

  assert_alt_no_detect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_board && mode_q == MODE_ASSUME) |=> mode_q == MODE_ASSUME);

  assert_legacy_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ASSUME && hit && hit_legacy) |=> mode_q == MODE_LEGACY);

endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import pci_irq_pkg::*;
#(
  parameter int unsigned NUM_DEV = 4
) (
  input  logic                        identity,
  input  logic                        alt_board,
  input  logic [NUM_DEV*4-1:0]        dev_intx,
  input  logic [NUM_DEV*SLOT_W-1:0]   dev_slot,
  output logic [3:0]                  host_irq
);
  logic [3:0] dev_lines [NUM_DEV];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [SLOT_W-1:0] slot;
    assign slot = dev_slot[d*SLOT_W +: SLOT_W];
    always_comb begin
      dev_lines[d] = '0;
      for (int p = 0; p < PINS_PER_DEV; p++) begin
        if (dev_intx[d*PINS_PER_DEV + p])
          dev_lines[d][route_index(slot, 2'(p), identity, alt_board)] = 1'b1;
      end
    end
  end

  always_comb begin
    host_irq = '0;
    for (int d = 0; d < NUM_DEV; d++) host_irq |= dev_lines[d];
  end

endmodule

// File: rtl/pci_intx_router.sv
module pci_intx_router
  import pci_irq_pkg::*;
#(
  parameter int unsigned NUM_DEV = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alt_board,
  input  logic                      cfg_wr_en,
  input  logic [23:0]               cfg_addr,
  input  logic [31:0]               cfg_wdata,
  input  logic [1:0]                cfg_size,
  input  logic [NUM_DEV*4-1:0]      dev_intx,
  input  logic [NUM_DEV*5-1:0]      dev_slot,
  output logic [3:0]                host_irq,
  output logic [1:0]                route_mode
);
  logic        snoop_hit;
  logic        snoop_legacy;
  route_mode_e mode_q;
  logic        identity_route;

  irq_cfg_snoop u_snoop (
    .detect_en  (!alt_board),
    .wr_en      (cfg_wr_en),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .size       (cfg_size),
    .hit        (snoop_hit),
    .hit_legacy (snoop_legacy)
  );

  irq_mode_tracker u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .alt_board  (alt_board),
    .hit        (snoop_hit),
    .hit_legacy (snoop_legacy),
    .mode_q     (mode_q)
  );

  assign identity_route = (mode_q == MODE_LEGACY);

  irq_pin_router #(.NUM_DEV(NUM_DEV)) u_route (
    .identity  (identity_route),
    .alt_board (alt_board),
    .dev_intx  (dev_intx),
    .dev_slot  (dev_slot),
    .host_irq  (host_irq)
  );

  assign route_mode = mode_q;

  assert_any_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_intx) == (|host_irq));

  assert_line_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(host_irq) <= $countones(dev_intx));

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    route_mode != 2'd3);

endmodule

// File: tb/tb_pci_intx_router.sv
`timescale 1ns/1ps
module tb_pci_intx_router;
  localparam int ND = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alt_board = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [23:0]   cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [1:0]    cfg_size = '0;
  logic [ND*4-1:0] dev_intx = '0;
  logic [ND*5-1:0] dev_slot = '0;
  logic [3:0]    host_irq;
  logic [1:0]    route_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pci_intx_router #(.NUM_DEV(ND)) dut (
    .clk(clk), .rst_n(rst_n), .alt_board(alt_board),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_size(cfg_size), .dev_intx(dev_intx), .dev_slot(dev_slot),
    .host_irq(host_irq), .route_mode(route_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input int slot, input logic [7:0] low, input logic [7:0] bus,
                           input logic [31:0] data, input logic [1:0] size);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = {bus, 5'(slot), 3'd0, low};
    cfg_wdata = data;
    cfg_size  = size;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // Sweep every slot and pin of device 0; offset k, or identity if k < 0.
  task automatic sweep(input string req, input int k);
    dev_intx = '0;
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        int idx;
        dev_slot = {5'd0, 5'(s)};
        dev_intx = 8'(1 << p);
        #1;
        idx = (k < 0) ? p : ((s + p + k) % 4);
        check(req, {28'd0, host_irq}, 32'(1 << idx));
      end
    end
    dev_intx = '0;
    #1;
  endtask

  initial begin
    do_reset();
    check("R1 reset mode", {30'd0, route_mode}, 0);
    check("R9 idle lines", {28'd0, host_irq}, 0);
    sweep("R7 rotated after reset (R1)", 2);

    cfg_write(0, 8'h38, 8'h00, 32'd27, 2'd2);
    check("R2 wrong offset ignored", {30'd0, route_mode}, 0);
    cfg_write(2, 8'h3C, 8'h00, 32'd27, 2'd0);
    check("R3 slot 2 ignored", {30'd0, route_mode}, 0);
    cfg_write(30, 8'h3C, 8'h00, 32'd27, 2'd0);
    check("R3 slot 30 ignored", {30'd0, route_mode}, 0);
    cfg_write(0, 8'h3C, 8'h00, 32'd27, 2'd3);
    check("R11 reserved size ignored", {30'd0, route_mode}, 0);
    alt_board = 1'b1;
    cfg_write(0, 8'h3C, 8'h00, 32'd27, 2'd0);
    check("R2 alt strap no detect", {30'd0, route_mode}, 0);
    sweep("R8 alt rotation", 3);
    alt_board = 1'b0;

    // R10 bus bits set, R4 upper data bits ignored
    cfg_write(1, 8'h3C, 8'hA5, 32'hFFFF_FF1B, 2'd2);
    check("R4 value 27 to identity (R10)", {30'd0, route_mode}, 1);
    sweep("R6 identity routing", -1);
    cfg_write(1, 8'h3C, 8'h00, 32'd9, 2'd0);
    check("R5 identity sticky", {30'd0, route_mode}, 1);
    alt_board = 1'b1;
    sweep("R8 alt overrides identity", 3);
    alt_board = 1'b0;

    do_reset();
    check("R1 mode after second reset", {30'd0, route_mode}, 0);
    cfg_write(31, 8'h3C, 8'h00, 32'h0000_1B0B, 2'd1);
    check("R4 other value to forced", {30'd0, route_mode}, 2);
    cfg_write(31, 8'h3C, 8'h00, 32'd27, 2'd0);
    check("R5 forced sticky", {30'd0, route_mode}, 2);
    sweep("R7 forced rotation", 2);

    // R9 all pin patterns of both devices, slots 29 and 30
    dev_slot = {5'd30, 5'd29};
    for (int v = 0; v < 256; v++) begin
      logic [3:0] exp;
      exp = '0;
      for (int d = 0; d < 2; d++)
        for (int p = 0; p < 4; p++)
          if (v[d*4+p]) exp[((29 + d) + p + 2) % 4] = 1'b1;
      dev_intx = 8'(v);
      #1;
      check("R9 OR merge", {28'd0, host_irq}, {28'd0, exp});
    end
    dev_intx = '0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule